// File: doc/BRIEF.md
# I2C Buffered-Mode Pool Transfer Controller

This block sits between the command sequencer of an I2C master and its byte-level bus engine. It serves the buffered transfer mode. A small byte-wide pool RAM holds the outgoing address byte and payload, and it collects incoming bytes. The host reaches the same RAM through a little-endian port that is 1 to 4 bytes wide. A 32-bit pool control word sets three things: where the active window starts in the pool, how many bytes to transmit, and how many to receive. The block writes the number of bytes actually received back into the top byte of that word.

The sequencer hands over one command at a time on a valid/ready handshake. A command carries three flags: start, transmit and receive. When a start is requested, the block first presents the address byte, which is window byte 0, with a start marker. It then streams payload bytes to the engine. Each byte waits for a single acknowledge/not-acknowledge response before the next byte is offered. After the transmit phase it accepts received bytes into the window. When a command finishes, the block reports a one-cycle done pulse with a NAK flag.

Engine back-pressure works as follows. A byte offered on `eng_tx_valid` stays offered, unchanged, until `eng_tx_ready` is seen. Receive bytes are taken only in cycles where both `eng_rx_ready` and `eng_rx_valid` are high. A command is accepted only while `cmd_ready` is high.

Top module: `pool_xfer_ctrl`

## Requirements
- R1: After reset the control word reads 0, `cmd_ready` is 1, and `eng_tx_valid`, `eng_rx_ready`, `done_valid`, `tx_buf_en` and `rx_buf_en` are all 0.
- R2: The control word layout is as follows. Bits 5:0 hold the window offset in 4-byte units. Bits 15:8 hold the transmit count minus 1. Bits 23:16 hold the receive size minus 1. Bits 31:24 hold the received-byte count. A software write (`ctl_we`) changes only bits 23:0, and bits 31:24 keep their value.
- R3: A host write stores `hst_len`+1 bytes, where lane k of `hst_wdata` (bits 8k+7:8k) goes to pool address `hst_addr`+k. A host read returns the bytes the same way, and lanes beyond the length read as 0.
- R4: When a command carries start, the first byte offered is pool[offset*4] with `eng_tx_start`=1.
- R5: A command with start and transmit, with a transmit count of 1, offers only the address byte.
- R6: Transmit offers window indices 0 through count-1. When the same command carried start, it begins at index 1 instead. Every payload byte has `eng_tx_start`=0.
- R7: A NAK response ends the command immediately. No further byte is offered, `done_nak` is 1, and both buffer-enable outputs are 0 the cycle after `done_valid`.
- R8: Receive stores size bytes at window indices 0 through size-1, in arrival order. It writes the size (mod 256) into bits 31:24, and `rx_buf_en` falls after done.
- R9: A command accepted while `sram_en` is 0 is rejected. `cmd_rejected` pulses in the next cycle, nothing is offered to the engine, and the buffer enables stay 0.
- R10: While `eng_tx_valid` is 1 and `eng_tx_ready` is 0, the offered byte and its start marker hold steady.
- R11: Every pool index, from the host or from a transfer, wraps modulo the pool size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sram_en | input | 1 | Global pool-RAM enable; commands are rejected while low |
| ctl_we | input | 1 | Software write strobe for the control word |
| ctl_wdata | input | 32 | Control word write data (bits 23:0 used) |
| ctl_rdata | output | 32 | Control word read value |
| hst_we | input | 1 | Host pool write strobe |
| hst_addr | input | 8 | Host pool byte address |
| hst_len | input | 2 | Host access width minus 1 |
| hst_wdata | input | 32 | Host write data, little-endian lanes |
| hst_rdata | output | 32 | Host read data, little-endian lanes |
| cmd_valid | input | 1 | Command offered by the sequencer |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_start | input | 1 | Command sends the address byte first |
| cmd_tx | input | 1 | Command has a transmit phase |
| cmd_rx | input | 1 | Command has a receive phase |
| cmd_rejected | output | 1 | One-cycle pulse: command refused for disabled RAM |
| eng_tx_valid | output | 1 | Byte offered to the bus engine |
| eng_tx_ready | input | 1 | Engine takes the offered byte |
| eng_tx_data | output | 8 | Offered byte |
| eng_tx_start | output | 1 | Offered byte is the address byte |
| eng_rsp_valid | input | 1 | Engine reports the bus response for the last byte |
| eng_rsp_nak | input | 1 | Response was not-acknowledge |
| eng_rx_valid | input | 1 | Engine presents a received byte |
| eng_rx_ready | output | 1 | Block takes received bytes |
| eng_rx_data | input | 8 | Received byte |
| done_valid | output | 1 | One-cycle pulse: command finished |
| done_nak | output | 1 | Finished command ended on a NAK |
| tx_buf_en | output | 1 | Transmit buffering active for current command |
| rx_buf_en | output | 1 | Receive buffering active for current command |

## Verification
Faults in window arithmetic show up on the first byte offered to the engine. A wrong base or start index gives a wrong `eng_tx_data` in the first offered cycle, and a wrong end check gives an extra or missing byte before `done_valid`. A stuck NAK path or buffer-enable flag is visible at most one cycle after the done pulse. Receive indexing errors appear in the host readback right after the command, and a lost count update appears in the top byte of `ctl_rdata` in the cycle `done_valid` is high.

// File: rtl/pool_xfer_pkg.sv
package pool_xfer_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ADDR,
    SQ_ADDR_WT,
    SQ_TX,
    SQ_TX_WT,
    SQ_RX,
    SQ_DONE
  } seq_state_e;

  localparam int CNT_W = 9;  // holds 1..256
endpackage

// File: rtl/pool_ram.sv
module pool_ram #(
  parameter int POOL_BYTES = 256,
  localparam int PIW = $clog2(POOL_BYTES)
) (
  input  logic           clk,
  input  logic           hst_we,
  input  logic [PIW-1:0] hst_addr,
  input  logic [1:0]     hst_len,
  input  logic [31:0]    hst_wdata,
  output logic [31:0]    hst_rdata,
  input  logic [PIW-1:0] eng_rd_idx,
  output logic [7:0]     eng_rd_data,
  input  logic           eng_we,
  input  logic [PIW-1:0] eng_wr_idx,
  input  logic [7:0]     eng_wdata
);
  logic [7:0] mem [POOL_BYTES];

  // engine write is last so it wins a same-byte collision
  always_ff @(posedge clk) begin
    if (hst_we) begin
      for (int k = 0; k < 4; k++) begin
        if (k <= int'(hst_len)) mem[hst_addr + PIW'(k)] <= hst_wdata[8*k +: 8];
      end
    end
    if (eng_we) mem[eng_wr_idx] <= eng_wdata;
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign hst_rdata[8*g +: 8] = (2'(g) <= hst_len) ? mem[hst_addr + PIW'(g)] : 8'h00;
  end

  assign eng_rd_data = mem[eng_rd_idx];
endmodule

// File: rtl/pool_ctl_reg.sv
module pool_ctl_reg
  import pool_xfer_pkg::*;
#(
  parameter int POOL_BYTES = 256,
  localparam int PIW = $clog2(POOL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  input  logic             cnt_we,
  input  logic [7:0]       cnt_val,
  output logic [31:0]      ctl_rdata,
  output logic [PIW-1:0]   win_base,
  output logic [CNT_W-1:0] tx_num,
  output logic [CNT_W-1:0] rx_num
);
  logic [31:0] ctl_q;
  logic [PIW+7:0] base_wide;

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else begin
      if (ctl_we) ctl_q[23:0] <= ctl_wdata[23:0];
      if (cnt_we) ctl_q[31:24] <= cnt_val;
    end
  end

  assign ctl_rdata = ctl_q;
  assign base_wide = {{PIW{1'b0}}, ctl_q[5:0], 2'b00};
  assign win_base  = base_wide[PIW-1:0];
  assign tx_num    = {1'b0, ctl_q[15:8]} + CNT_W'(1);
  assign rx_num    = {1'b0, ctl_q[23:16]} + CNT_W'(1);

  AST_CNT_SW_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !cnt_we) |=> $stable(ctl_q[31:24])); // R2
endmodule

// File: rtl/pool_seq.sv
module pool_seq
  import pool_xfer_pkg::*;
#(
  parameter int POOL_BYTES = 256,
  localparam int PIW = $clog2(POOL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sram_en,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_start,
  input  logic             cmd_tx,
  input  logic             cmd_rx,
  output logic             cmd_rejected,
  input  logic [PIW-1:0]   win_base,
  input  logic [CNT_W-1:0] tx_num,
  input  logic [CNT_W-1:0] rx_num,
  output logic             eng_tx_valid,
  input  logic             eng_tx_ready,
  output logic             eng_tx_start,
  input  logic             eng_rsp_valid,
  input  logic             eng_rsp_nak,
  input  logic             eng_rx_valid,
  output logic             eng_rx_ready,
  output logic [PIW-1:0]   pool_idx,
  output logic             pool_we,
  output logic             cnt_we,
  output logic [7:0]       cnt_val,
  output logic             done_valid,
  output logic             done_nak,
  output logic             tx_buf_en,
  output logic             rx_buf_en
);
  seq_state_e       st;
  logic [PIW-1:0]   base_q;
  logic [CNT_W-1:0] txn_q, rxn_q, idx_q, idx_nx;
  logic             nak_q, rej_q, txen_q, rxen_q;

  assign idx_nx = idx_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SQ_IDLE; base_q <= '0; txn_q <= '0; rxn_q <= '0; idx_q <= '0;
      nak_q <= 1'b0; rej_q <= 1'b0; txen_q <= 1'b0; rxen_q <= 1'b0;
    end else begin
      rej_q <= 1'b0;
      case (st)
        SQ_IDLE: if (cmd_valid) begin
          if (!sram_en) rej_q <= 1'b1;
          else begin
            base_q <= win_base; txn_q <= tx_num; rxn_q <= rx_num;
            txen_q <= cmd_tx; rxen_q <= cmd_rx; nak_q <= 1'b0; idx_q <= '0;
            if (cmd_start)   st <= SQ_ADDR;
            else if (cmd_tx) st <= SQ_TX;
            else if (cmd_rx) st <= SQ_RX;
            else             st <= SQ_DONE;
          end
        end
        SQ_ADDR: if (eng_tx_ready) st <= SQ_ADDR_WT;
        SQ_ADDR_WT: if (eng_rsp_valid) begin
          if (eng_rsp_nak) begin nak_q <= 1'b1; st <= SQ_DONE; end
          else if (txen_q && txn_q > CNT_W'(1)) begin idx_q <= CNT_W'(1); st <= SQ_TX; end
          else if (rxen_q) begin idx_q <= '0; st <= SQ_RX; end
          else st <= SQ_DONE;
        end
        SQ_TX: if (eng_tx_ready) st <= SQ_TX_WT;
        SQ_TX_WT: if (eng_rsp_valid) begin
          if (eng_rsp_nak) begin nak_q <= 1'b1; st <= SQ_DONE; end
          else if (idx_nx < txn_q) begin idx_q <= idx_nx; st <= SQ_TX; end
          else if (rxen_q) begin idx_q <= '0; st <= SQ_RX; end
          else st <= SQ_DONE;
        end
        SQ_RX: if (eng_rx_valid) begin
          idx_q <= idx_nx;
          if (idx_nx == rxn_q) st <= SQ_DONE;
        end
        SQ_DONE: begin
          st <= SQ_IDLE; txen_q <= 1'b0; rxen_q <= 1'b0;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign cmd_ready    = (st == SQ_IDLE);
  assign cmd_rejected = rej_q;
  assign eng_tx_valid = (st == SQ_ADDR) || (st == SQ_TX);
  assign eng_tx_start = (st == SQ_ADDR);
  assign eng_rx_ready = (st == SQ_RX);
  assign pool_idx     = base_q + PIW'(idx_q);
  assign pool_we      = eng_rx_ready && eng_rx_valid;
  assign cnt_we       = pool_we && (idx_nx == rxn_q);
  assign cnt_val      = idx_nx[7:0];
  assign done_valid   = (st == SQ_DONE);
  assign done_nak     = nak_q;
  assign tx_buf_en    = txen_q;
  assign rx_buf_en    = rxen_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_valid && !eng_tx_ready) |=> (eng_tx_valid && $stable(pool_idx) && $stable(eng_tx_start))); // R10
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!tx_buf_en && !rx_buf_en)); // R7
  AST_NO_FALSE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && sram_en) |=> !cmd_rejected); // R9
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_ready |-> (idx_q < rxn_q)); // R8
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rejected |-> (!eng_tx_valid && !tx_buf_en && !rx_buf_en)); // R9
endmodule

// File: rtl/pool_xfer_ctrl.sv
module pool_xfer_ctrl
  import pool_xfer_pkg::*;
#(
  parameter int POOL_BYTES = 256,
  localparam int PIW = $clog2(POOL_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sram_en,
  input  logic           ctl_we,
  input  logic [31:0]    ctl_wdata,
  output logic [31:0]    ctl_rdata,
  input  logic           hst_we,
  input  logic [PIW-1:0] hst_addr,
  input  logic [1:0]     hst_len,
  input  logic [31:0]    hst_wdata,
  output logic [31:0]    hst_rdata,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_start,
  input  logic           cmd_tx,
  input  logic           cmd_rx,
  output logic           cmd_rejected,
  output logic           eng_tx_valid,
  input  logic           eng_tx_ready,
  output logic [7:0]     eng_tx_data,
  output logic           eng_tx_start,
  input  logic           eng_rsp_valid,
  input  logic           eng_rsp_nak,
  input  logic           eng_rx_valid,
  output logic           eng_rx_ready,
  input  logic [7:0]     eng_rx_data,
  output logic           done_valid,
  output logic           done_nak,
  output logic           tx_buf_en,
  output logic           rx_buf_en
);
  logic [PIW-1:0]   win_base, pool_idx;
  logic [CNT_W-1:0] tx_num, rx_num;
  logic             pool_we, cnt_we;
  logic [7:0]       cnt_val;

  pool_ctl_reg #(.POOL_BYTES(POOL_BYTES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cnt_we(cnt_we), .cnt_val(cnt_val), .ctl_rdata(ctl_rdata),
    .win_base(win_base), .tx_num(tx_num), .rx_num(rx_num)
  );

  pool_seq #(.POOL_BYTES(POOL_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .sram_en(sram_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_start(cmd_start),
    .cmd_tx(cmd_tx), .cmd_rx(cmd_rx), .cmd_rejected(cmd_rejected),
    .win_base(win_base), .tx_num(tx_num), .rx_num(rx_num),
    .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_start(eng_tx_start),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_nak(eng_rsp_nak),
    .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready),
    .pool_idx(pool_idx), .pool_we(pool_we), .cnt_we(cnt_we), .cnt_val(cnt_val),
    .done_valid(done_valid), .done_nak(done_nak),
    .tx_buf_en(tx_buf_en), .rx_buf_en(rx_buf_en)
  );

  pool_ram #(.POOL_BYTES(POOL_BYTES)) u_ram (
    .clk(clk), .hst_we(hst_we), .hst_addr(hst_addr), .hst_len(hst_len),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .eng_rd_idx(pool_idx), .eng_rd_data(eng_tx_data),
    .eng_we(pool_we), .eng_wr_idx(pool_idx), .eng_wdata(eng_rx_data)
  );

  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_tx_valid && eng_rx_ready)); // R6
endmodule

// File: tb/tb_pool_xfer_ctrl.sv
module tb_pool_xfer_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sram_en = 1'b1, ctl_we = 1'b0, hst_we = 1'b0;
  logic [31:0] ctl_wdata = '0, hst_wdata = '0, ctl_rdata, hst_rdata;
  logic [7:0] hst_addr = '0;
  logic [1:0] hst_len = '0;
  logic cmd_valid = 1'b0, cmd_start = 1'b0, cmd_tx = 1'b0, cmd_rx = 1'b0;
  logic cmd_ready, cmd_rejected, eng_tx_valid, eng_tx_start, eng_rx_ready;
  logic eng_tx_ready = 1'b0, eng_rsp_valid = 1'b0, eng_rsp_nak = 1'b0, eng_rx_valid = 1'b0;
  logic [7:0] eng_tx_data, eng_rx_data = '0;
  logic done_valid, done_nak, tx_buf_en, rx_buf_en;

  int checks = 0, errors = 0;
  logic [7:0] log_d [16];
  logic       log_s [16];
  int  nsent, nrx;
  bit  got_nak, got_rej, seen_en;

  always #2 clk = ~clk;

  pool_xfer_ctrl dut (.*);

  // {we, addr, len, wdata, expected read}
  localparam logic [74:0] VEC [0:8] = '{
    {1'b1, 8'h10, 2'd3, 32'h44332211, 32'h0},
    {1'b0, 8'h10, 2'd3, 32'h0, 32'h44332211},
    {1'b0, 8'h11, 2'd0, 32'h0, 32'h00000022},
    {1'b0, 8'h12, 2'd1, 32'h0, 32'h00004433},
    {1'b1, 8'h13, 2'd0, 32'h000000AB, 32'h0},
    {1'b0, 8'h10, 2'd3, 32'h0, 32'hAB332211},
    {1'b1, 8'hFE, 2'd3, 32'hDDCCBBAA, 32'h0},
    {1'b0, 8'h00, 2'd1, 32'h0, 32'h0000DDCC},
    {1'b0, 8'hFF, 2'd1, 32'h0, 32'h0000CCBB}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wctl(input logic [31:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic hwr(input logic [7:0] a, input logic [1:0] l, input logic [31:0] d);
    @(negedge clk); hst_we = 1'b1; hst_addr = a; hst_len = l; hst_wdata = d;
    @(negedge clk); hst_we = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, input logic [1:0] l, output logic [31:0] d);
    @(negedge clk); hst_addr = a; hst_len = l; #1 d = hst_rdata;
  endtask

  task automatic run_cmd(input bit s, input bit t, input bit r, input int nak_at, input int stall);
    bit pend = 0, fin = 0;
    int sl = stall;
    nsent = 0; nrx = 0; got_nak = 0; got_rej = 0; seen_en = 0;
    @(negedge clk); cmd_valid = 1'b1; cmd_start = s; cmd_tx = t; cmd_rx = r;
    for (int c = 0; c < 300 && !fin; c++) begin
      @(negedge clk);
      cmd_valid = 1'b0; eng_tx_ready = 1'b0; eng_rsp_valid = 1'b0;
      eng_rsp_nak = 1'b0; eng_rx_valid = 1'b0;
      if (tx_buf_en) seen_en = 1;
      if (done_valid) begin got_nak = done_nak; fin = 1; end
      else if (cmd_rejected) begin got_rej = 1; fin = 1; end
      else begin
        if (pend) begin
          eng_rsp_valid = 1'b1; eng_rsp_nak = (nsent - 1 == nak_at); pend = 0;
        end else if (eng_tx_valid) begin
          if (sl > 0) sl--;
          else begin
            eng_tx_ready = 1'b1;
            if (nsent < 16) begin log_d[nsent] = eng_tx_data; log_s[nsent] = eng_tx_start; end
            nsent++; pend = 1; sl = stall;
          end
        end
        if (eng_rx_ready) begin
          eng_rx_valid = 1'b1; eng_rx_data = 8'hA0 + 8'(nrx); nrx++;
        end
      end
    end
    if (!fin) check("cmd completion", 32'd0, 32'd1);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctl", ctl_rdata, 32'h0);
    check("R1 idle outputs", {cmd_ready, eng_tx_valid, eng_rx_ready, done_valid, tx_buf_en, rx_buf_en},
          32'b100000);

    // R3 R11 table walk
    for (int i = 0; i < 9; i++) begin
      if (VEC[i][74]) hwr(VEC[i][73:66], VEC[i][65:64], VEC[i][63:32]);
      else begin
        hrd(VEC[i][73:66], VEC[i][65:64], rd);
        check($sformatf("R3/R11 host vec %0d", i), rd, VEC[i][31:0]);
      end
    end

    wctl(32'hFFFFFFFF);
    check("R2 sw write mask", ctl_rdata, 32'h00FFFFFF);

    // R4 R5: start+tx, count 1, offset 4 (base 0x10)
    wctl(32'h00000004);
    run_cmd(1, 1, 0, -1, 0);
    check("R5 only address", nsent, 1);
    check("R4 address byte", {log_s[0], log_d[0]}, {1'b1, 8'h11});

    // R6 R10: start+tx count 4 with stalls
    wctl(32'h00000304);
    run_cmd(1, 1, 0, -1, 2);
    check("R6 count after start", nsent, 4);
    check("R6/R10 bytes", {log_d[0], log_d[1], log_d[2], log_d[3]}, 32'h112233AB);
    check("R6 start marks", {log_s[0], log_s[1], log_s[2], log_s[3]}, 4'b1000);

    // R6 tx without start begins at index 0
    wctl(32'h00000204);
    run_cmd(0, 1, 0, -1, 0);
    check("R6 no-start count", nsent, 3);
    check("R6 no-start bytes", {log_s[0], log_d[0], log_d[1], log_d[2]}, {1'b0, 24'h112233});

    // R7 NAK on second byte
    wctl(32'h00000304);
    run_cmd(1, 1, 0, 1, 0);
    check("R7 stop at nak", nsent, 2);
    check("R7 done_nak", got_nak, 1);
    check("R7 en seen then cleared", {seen_en, tx_buf_en}, 2'b10);

    // R8 receive 3 bytes
    wctl(32'h00020004);
    run_cmd(0, 0, 1, -1, 0);
    check("R8 count field", ctl_rdata, 32'h03020004);
    check("R8 rx_buf_en cleared", rx_buf_en, 0);
    hrd(8'h10, 2'd3, rd);
    check("R8 stored bytes", rd, 32'hABA2A1A0);
    wctl(32'h00000000);
    check("R2 count kept", ctl_rdata, 32'h03000000);

    // R9 reject
    wctl(32'h00000304);
    sram_en = 1'b0;
    run_cmd(1, 1, 0, -1, 0);
    check("R9 rejected", got_rej, 1);
    check("R9 nothing sent", nsent, 0);
    check("R9 enables low", {seen_en, tx_buf_en}, 0);
    sram_en = 1'b1;

    // R11 window wrap: offset 63 -> base 0xFC, 6 bytes
    hwr(8'hFC, 2'd3, 32'h04030201);
    wctl(32'h0000053F);
    run_cmd(0, 1, 0, -1, 1);
    check("R11 wrap count", nsent, 6);
    check("R11 wrap head", {log_d[0], log_d[1], log_d[2], log_d[3]}, 32'h01020304);
    check("R11 wrap tail", {log_d[4], log_d[5]}, 16'hCCDD);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule